// File: doc/BRIEF.md
# Timer interrupt flag and mask unit

This block keeps the interrupt state of a 16-bit timer that has one compare channel. It watches the running counter value and the compare value. On cycles where the timer clock-enable strobe is high, it records a compare-match event and a wrap (overflow) event in two sticky flag bits. Software reads both flags through a byte-wide register bus. It clears a flag by writing a one to that flag's bit position. The CPU's interrupt logic can also clear a flag in hardware by pulsing a per-vector acknowledge input when it enters the vector.

A second byte-wide register holds one enable bit per source. Each interrupt request output is registered. It is high when, in the previous cycle, the flag was set, its enable bit was set and the global interrupt enable input was high. The counter itself, clock prescaling and waveform generation sit outside this block. The bus has no wait states: writes take effect at the clock edge and reads are combinational on the address.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset, both registers read 0x00 and both interrupt request outputs are low.
- R2: The enable register is at bus address 0x6F. Bit 1 enables the compare request and bit 0 enables the overflow request. A write with the strobe high stores bits 1:0, and bits 7:2 always read zero.
- R3: The flag register is at bus address 0x36. Bit 1 is the compare flag and bit 0 is the overflow flag. Bits 7:2 always read zero.
- R4: In a cycle where the tick input is high and the counter equals the compare value, the compare flag reads 1 from the next cycle on.
- R5: In a cycle where the tick input is high and the counter is all ones (0xFFFF), the overflow flag reads 1 from the next cycle on.
- R6: While the tick input is low, neither flag is set, whatever the counter and compare values are.
- R7: Writing a one to a flag bit clears that flag from the next cycle on. Writing a zero to a flag bit leaves it unchanged.
- R8: A one-cycle pulse on the compare acknowledge input clears only the compare flag. A pulse on the overflow acknowledge input clears only the overflow flag.
- R9: When a set event and a clear (by write or by acknowledge) fall in the same cycle, the flag ends up set.
- R10: Each request output equals the AND of its flag, its enable bit and the global enable, as they stood in the previous cycle. A request therefore drops one cycle after any of the three goes low.
- R11: Any other bus address reads 0x00, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| tmr_tick | input | 1 | Timer clock enable; high on cycles the counter advances |
| tmr_cnt | input | 16 | Current counter value |
| tmr_cmp | input | 16 | Compare channel value |
| gie | input | 1 | Global interrupt enable |
| ack_cmp | input | 1 | Compare vector acknowledge pulse |
| ack_ovf | input | 1 | Overflow vector acknowledge pulse |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The random stimulus biases the counter toward the compare value and toward all ones. This makes both flags set often. Ticks, acknowledges, the global enable and writes to the enable register, the flag register and stray addresses are randomised on top of that, so set, clear and gating orders all occur, including many same-cycle collisions. Directed cases separate four things. Equality without a tick must leave the flags clear. A write of zeros must not disturb the flags. A set that coincides with a write-one must win. An acknowledge must clear only its own source. Comparing both request outputs every cycle shows whether each request lags its flag by exactly one cycle and drops one cycle after its enable or the global enable goes low.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   localparam int NUM_SRC = 2;
   localparam int SRC_OVF = 0;
   localparam int SRC_CMP = 1;
   typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/tmr_evt_detect.sv
module tmr_evt_detect
   import tmr_irq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   output src_vec_t         hit
);
   always_comb begin
      hit          = '0;
      hit[SRC_CMP] = tick && (cnt == cmp);
      hit[SRC_OVF] = tick && (&cnt);
   end
endmodule

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // a set event outranks any clear arriving in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set | (q & ~clr);
   end
endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
   import tmr_irq_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter logic [7:0]  MASK_ADDR = 8'h6F,
   parameter logic [7:0]  FLAG_ADDR = 8'h36
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  src_vec_t          en_q,
   input  src_vec_t          flags_q,
   output logic              mask_we,
   output logic              flag_we,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);
   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

   logic hit_mask;
   logic hit_flag;

   assign hit_mask = (addr == MASK_A);
   assign hit_flag = (addr == FLAG_A);
   assign mask_we  = we && hit_mask;
   assign flag_we  = we && hit_flag;

   always_comb begin
      rdata = '0;
      if (hit_mask)      rdata[NUM_SRC-1:0] = en_q;
      else if (hit_flag) rdata[NUM_SRC-1:0] = flags_q;
   end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
   import tmr_irq_pkg::*;
#(
   parameter int          CNT_W     = 16,
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter logic [7:0]  MASK_ADDR = 8'h6F,
   parameter logic [7:0]  FLAG_ADDR = 8'h36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tmr_tick,
   input  logic [CNT_W-1:0]  tmr_cnt,
   input  logic [CNT_W-1:0]  tmr_cmp,
   input  logic              gie,
   input  logic              ack_cmp,
   input  logic              ack_ovf,
   output logic              irq_cmp,
   output logic              irq_ovf
);
   if (DATA_W <= NUM_SRC) begin : g_bad_data_w
      $error("DATA_W must exceed the number of interrupt sources");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end
   if (MASK_ADDR == FLAG_ADDR) begin : g_bad_map
      $error("enable and flag registers must sit at distinct addresses");
   end

   src_vec_t en_q;
   src_vec_t flags_q;
   src_vec_t hit;
   src_vec_t ack_vec;
   src_vec_t irq_q;
   logic     mask_we;
   logic     flag_we;
   logic     unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_SRC];

   always_comb begin
      ack_vec          = '0;
      ack_vec[SRC_CMP] = ack_cmp;
      ack_vec[SRC_OVF] = ack_ovf;
   end

   tmr_evt_detect #(.CNT_W(CNT_W)) u_detect (
      .tick (tmr_tick),
      .cnt  (tmr_cnt),
      .cmp  (tmr_cmp),
      .hit  (hit)
   );

   tmr_regbus #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .MASK_ADDR (MASK_ADDR),
      .FLAG_ADDR (FLAG_ADDR)
   ) u_regbus (
      .addr    (bus_addr),
      .we      (bus_we),
      .en_q    (en_q),
      .flags_q (flags_q),
      .mask_we (mask_we),
      .flag_we (flag_we),
      .rdata   (bus_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (mask_we) en_q <= bus_wdata[NUM_SRC-1:0];
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic clr_i;
      assign clr_i = (flag_we && bus_wdata[i]) || ack_vec[i];

      tmr_flag_bit u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (hit[i]),
         .clr   (clr_i),
         .q     (flags_q[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q[i] <= 1'b0;
         else        irq_q[i] <= flags_q[i] && en_q[i] && gie;
      end
   end

   assign irq_cmp = irq_q[SRC_CMP];
   assign irq_ovf = irq_q[SRC_OVF];
endmodule

// File: rtl/tmr_irq_unit_chk.sv
module tmr_irq_unit_chk
   import tmr_irq_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tmr_tick,
   input logic [CNT_W-1:0]  tmr_cnt,
   input logic [CNT_W-1:0]  tmr_cmp,
   input logic              gie,
   input logic              ack_cmp,
   input logic              ack_ovf,
   input logic              irq_cmp,
   input logic              irq_ovf,
   input logic [DATA_W-1:0] bus_rdata,
   input src_vec_t          en_q,
   input src_vec_t          flags_q
);
   // R3
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:NUM_SRC] == '0);

   // R4
   cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_tick && tmr_cnt == tmr_cmp) |=> flags_q[SRC_CMP]);

   // R5
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_tick && (&tmr_cnt)) |=> flags_q[SRC_OVF]);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_tick && flags_q == '0) |=> flags_q == '0);

   // R8
   ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_cmp && !(tmr_tick && tmr_cnt == tmr_cmp)) |=> !flags_q[SRC_CMP]);

   // R8
   ack_ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ovf && !(tmr_tick && (&tmr_cnt))) |=> !flags_q[SRC_OVF]);

   // R10
   irq_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |=> (!irq_cmp && !irq_ovf));

   // R10
   irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_cmp == $past(flags_q[SRC_CMP] && en_q[SRC_CMP] && gie));
endmodule

bind tmr_irq_unit tmr_irq_unit_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tmr_tick  (tmr_tick),
   .tmr_cnt   (tmr_cnt),
   .tmr_cmp   (tmr_cmp),
   .gie       (gie),
   .ack_cmp   (ack_cmp),
   .ack_ovf   (ack_ovf),
   .irq_cmp   (irq_cmp),
   .irq_ovf   (irq_ovf),
   .bus_rdata (bus_rdata),
   .en_q      (en_q),
   .flags_q   (flags_q)
);

// File: tb/tmr_irq_unit_bench.sv
module tmr_irq_unit_bench;
   localparam logic [7:0] A_MASK = 8'h6F;
   localparam logic [7:0] A_FLAG = 8'h36;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        tmr_tick = 1'b0;
   logic [15:0] tmr_cnt = '0;
   logic [15:0] tmr_cmp = 16'h0100;
   logic        gie = 1'b0;
   logic        ack_cmp = 1'b0;
   logic        ack_ovf = 1'b0;
   logic        irq_cmp;
   logic        irq_ovf;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // expected state, bit1 = compare, bit0 = overflow
   logic [1:0] m_en = '0;
   logic [1:0] m_flg = '0;
   logic [1:0] m_irq = '0;

   always #5 clk = ~clk;

   tmr_irq_unit u_tmr_irq_unit (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_tick(tmr_tick),
      .tmr_cnt(tmr_cnt), .tmr_cmp(tmr_cmp), .gie(gie), .ack_cmp(ack_cmp),
      .ack_ovf(ack_ovf), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
   );

   function automatic logic [7:0] exp_read(logic [7:0] a);
      if (a == A_MASK) return {6'b0, m_en};
      if (a == A_FLAG) return {6'b0, m_flg};
      return 8'h00;
   endfunction

   function automatic string tag_of(logic [7:0] a);
      if (a == A_MASK) return "R2";
      if (a == A_FLAG) return "R3";
      return "R11";
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   // expected state after one clock edge, from the requirements
   task automatic model_step();
      logic [1:0] hit, clr, nf;
      hit[1] = tmr_tick && (tmr_cnt == tmr_cmp);
      hit[0] = tmr_tick && (tmr_cnt == 16'hFFFF);
      clr[1] = (bus_we && bus_addr == A_FLAG && bus_wdata[1]) || ack_cmp;
      clr[0] = (bus_we && bus_addr == A_FLAG && bus_wdata[0]) || ack_ovf;
      nf = hit | (m_flg & ~clr);
      m_irq = m_flg & m_en & {gie, gie};
      if (bus_we && bus_addr == A_MASK) m_en = bus_wdata[1:0];
      m_flg = nf;
   endtask

   // one bus cycle: drive at negedge, compare, then let the edge pass
   task automatic cyc(input logic [7:0] a, input logic we, input logic [7:0] wd,
                      input logic tk, input logic [15:0] cn, input logic ac,
                      input logic ao, input logic g);
      @(negedge clk);
      bus_addr = a; bus_we = we; bus_wdata = wd; tmr_tick = tk; tmr_cnt = cn;
      ack_cmp = ac; ack_ovf = ao; gie = g;
      #1;
      check(tag_of(a), bus_rdata, exp_read(a));
      check("R10", {6'b0, irq_cmp, irq_ovf}, {6'b0, m_irq});
      @(posedge clk);
      model_step();
   endtask

   task automatic rd(input logic [7:0] a);
      cyc(a, 1'b0, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, gie);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1: watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state
      repeat (2) @(negedge clk);
      bus_addr = A_MASK; #1; check("R1", bus_rdata, 8'h00);
      bus_addr = A_FLAG; #1; check("R1", bus_rdata, 8'h00);
      check("R1", {6'b0, irq_cmp, irq_ovf}, 8'h00);
      @(negedge clk); rst_n = 1'b1;

      // R2: enable write, reserved bits read zero
      cyc(A_MASK, 1'b1, 8'hFF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
      rd(A_MASK);
      check("R2", bus_rdata, 8'h03);
      // R6: equality without a tick sets nothing
      cyc(A_FLAG, 1'b0, 8'h00, 1'b0, tmr_cmp, 1'b0, 1'b0, 1'b1);
      cyc(A_FLAG, 1'b0, 8'h00, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b1);
      rd(A_FLAG);
      check("R6", bus_rdata, 8'h00);
      // R4 and R5: ticked events set flags in the next cycle
      cyc(A_FLAG, 1'b0, 8'h00, 1'b1, tmr_cmp, 1'b0, 1'b0, 1'b1);
      rd(A_FLAG);
      check("R4", bus_rdata, 8'h02);
      cyc(A_FLAG, 1'b0, 8'h00, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1);
      rd(A_FLAG);
      check("R5", bus_rdata, 8'h03);
      // R10: request follows one cycle later
      rd(A_FLAG);
      check("R10", {6'b0, irq_cmp, irq_ovf}, 8'h03);
      // R7: write zero keeps, write one clears
      cyc(A_FLAG, 1'b1, 8'h00, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
      rd(A_FLAG);
      check("R7", bus_rdata, 8'h03);
      cyc(A_FLAG, 1'b1, 8'h01, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
      rd(A_FLAG);
      check("R7", bus_rdata, 8'h02);
      // R8: compare ack clears only the compare flag
      cyc(A_FLAG, 1'b0, 8'h00, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1);
      cyc(A_FLAG, 1'b0, 8'h00, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
      rd(A_FLAG);
      check("R8", bus_rdata, 8'h01);
      // R9: set together with write-one and ack stays set
      cyc(A_FLAG, 1'b1, 8'h03, 1'b1, tmr_cmp, 1'b1, 1'b0, 1'b1);
      rd(A_FLAG);
      check("R9", bus_rdata, 8'h02);
      // R11: stray address write changes nothing
      cyc(8'h10, 1'b1, 8'hFF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
      rd(A_MASK);
      check("R11", bus_rdata, 8'h03);
      rd(A_FLAG);
      check("R11", bus_rdata, 8'h02);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [7:0]  a;
         logic [15:0] cn;
         int sel;
         sel = int'($urandom % 4);
         if (sel == 0)      a = A_MASK;
         else if (sel == 1) a = 8'($urandom);
         else               a = A_FLAG;
         sel = int'($urandom % 4);
         if (sel == 0)      cn = tmr_cmp;
         else if (sel == 1) cn = 16'hFFFF;
         else               cn = 16'($urandom);
         cyc(a, ($urandom % 4) == 0, 8'($urandom), ($urandom % 2) == 0, cn,
             ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 4) != 0);
      end
      rd(A_FLAG);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule